// File: doc/BRIEF.md
# Vigenère Sequencing Cipher Engine

This block encrypts or decrypts a stored string of letter codes against a stored keyword. Letters are 5-bit codes, A = 0 up to Z = 25. A start pulse launches a run. The engine then walks the text one position per clock cycle, in ascending index order. For each position it takes the matching keyword letter and applies a modulo-26 add when encrypting, or a modulo-26 subtract when decrypting. The result is written into the same position of a flat result array. The keyword index wraps to zero on its own counter, so a short keyword repeats across a longer message.

The surrounding logic holds the flat text and key arrays stable while a run is in progress. Those arrays are read live. The text length, the key length and the mode are captured when a start is accepted. A done flag signals completion and stays high until the next accepted start. In a flat array, character i occupies bits [5i+4:5i]. mode_i = 0 selects encryption and mode_i = 1 selects decryption.

Top module: `vig_seq_engine`

## Requirements
- R1: With mode 0 captured at start, each processed position i gets result[i] = (text[i] + keychar) mod 26, where A = 0 … Z = 25 in 5-bit codes.
- R2: With mode 1 captured at start, each processed position i gets result[i] = (text[i] + 26 − keychar) mod 26, which never underflows.
- R3: The key character used at text position i is key[i mod K], where K is the captured key length. The key index wraps to 0 independently of the text index.
- R4: A captured key length of 0 behaves as a one-letter key of A (code 0), so the result equals the text in either mode.
- R5: Mode, text length and key length are sampled on the accepted start, and changing them during a run has no effect on that run.
- R6: A start pulse that arrives while a run is in progress is ignored. The run keeps its timing and its result.
- R7: If a start is accepted at clock edge 0 with effective text length N, done is low after edges 1..N and high after edge N+1. Done stays high until the next accepted start, and a start is accepted while done is high.
- R8: After reset, done is low and every result position is 0.
- R9: A text length of 0 raises done one edge after the start and writes no result position.
- R10: A text length above MAX_TEXT is processed as MAX_TEXT, and a key length above MAX_KEY is used as MAX_KEY.
- R11: Result positions at or beyond the current run's text length keep their previous values.
- R12: Encrypting SECRETMESSAGE with key KRYPTOS yields CVAGXHEOJQPZS, and decrypting that yields SECRETMESSAGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted when no run is in progress |
| mode_i | input | 1 | 0 = encrypt, 1 = decrypt; sampled on accepted start |
| text_i | input | MAX_TEXT*5 | Flat text array, character i at bits [5i+4:5i] |
| text_len_i | input | TLEN_W | Number of text characters to process |
| key_i | input | MAX_KEY*5 | Flat keyword array, character j at bits [5j+4:5j] |
| key_len_i | input | KLEN_W | Keyword length; 0 means no shift |
| result_o | output | MAX_TEXT*5 | Flat result array |
| done_o | output | 1 | High from run completion until the next accepted start |

## Verification
The hardest situation to reach from the ports is a start pulse landing in the middle of a run. The same pulse carries a different mode and different lengths, so that accepting it would visibly change both the finish cycle and the result. The bench raises start three cycles into a sixteen-character run, with the mode flipped and the lengths shortened. It then checks that done rises on the original cycle count and that the result matches the original parameters. Key wrap with a keyword length that does not divide the text length, and the zero-length key, are each driven in their own scenario. Each scenario is compared against a reference computed by plain modulo arithmetic in the bench.

// File: rtl/vig_pkg.sv
package vig_pkg;
   localparam int CHAR_W = 5;
   localparam int ALPHA  = 26;

   typedef logic [CHAR_W-1:0] letter_t;

   typedef enum logic {
      OP_ENC = 1'b0,
      OP_DEC = 1'b1
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/vig_mod26_unit.sv
module vig_mod26_unit
   import vig_pkg::*;
#(
   parameter bit SHARED_ADDER = 1'b1
) (
   input  op_e     op_i,
   input  letter_t txt_i,
   input  letter_t key_i,
   output letter_t res_o
);
   localparam int WIDE_W = CHAR_W + 1;
   localparam logic [WIDE_W-1:0] ALPHA_W = WIDE_W'(ALPHA);

   logic [WIDE_W-1:0] txt_w;
   logic [WIDE_W-1:0] key_w;
   logic [WIDE_W-1:0] sum_w;

   assign txt_w = {1'b0, txt_i};
   assign key_w = {1'b0, key_i};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [WIDE_W-1:0] addend;
         assign addend = (op_i == OP_DEC) ? (ALPHA_W - key_w) : key_w;
         assign sum_w  = txt_w + addend;
      end else begin : g_split
         logic [WIDE_W-1:0] s_enc;
         logic [WIDE_W-1:0] s_dec;
         assign s_enc = txt_w + key_w;
         assign s_dec = txt_w + ALPHA_W - key_w;
         assign sum_w = (op_i == OP_DEC) ? s_dec : s_enc;
      end
   endgenerate

   logic [WIDE_W-1:0] red_w;
   assign red_w = (sum_w >= ALPHA_W) ? (sum_w - ALPHA_W) : sum_w;
   assign res_o = red_w[CHAR_W-1:0];
endmodule

// File: rtl/vig_index_ctrl.sv
module vig_index_ctrl
   import vig_pkg::*;
#(
   parameter int MAX_TEXT = 16,
   parameter int MAX_KEY  = 8,
   parameter int TLEN_W   = $clog2(MAX_TEXT + 1),
   parameter int KLEN_W   = $clog2(MAX_KEY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [TLEN_W-1:0] text_len_i,
   input  logic [KLEN_W-1:0] key_len_i,
   output logic              run_o,
   output logic              done_o,
   output op_e               op_o,
   output logic              keyless_o,
   output logic              wr_en_o,
   output logic [TLEN_W-1:0] tidx_o,
   output logic [TLEN_W-1:0] tlen_o,
   output logic [KLEN_W-1:0] kidx_o,
   output logic [KLEN_W-1:0] klen_o
);
   localparam logic [TLEN_W-1:0] TMAX = TLEN_W'(MAX_TEXT);
   localparam logic [KLEN_W-1:0] KMAX = KLEN_W'(MAX_KEY);

   seq_state_e        state_q;
   op_e               op_q;
   logic              keyless_q;
   logic [TLEN_W-1:0] tidx_q, tlen_q;
   logic [KLEN_W-1:0] kidx_q, klen_q;

   logic              accept;
   logic [TLEN_W-1:0] tlen_c;
   logic [KLEN_W-1:0] klen_c;
   logic              step;

   assign accept = start_i && (state_q != ST_RUN);
   assign tlen_c = (text_len_i > TMAX) ? TMAX : text_len_i;
   assign klen_c = (key_len_i == '0) ? KLEN_W'(1)
                 : (key_len_i > KMAX) ? KMAX : key_len_i;
   assign step   = (state_q == ST_RUN) && (tidx_q != tlen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_ENC;
         keyless_q <= 1'b0;
         tidx_q    <= '0;
         tlen_q    <= '0;
         kidx_q    <= '0;
         klen_q    <= KLEN_W'(1);
      end else if (accept) begin
         state_q   <= ST_RUN;
         op_q      <= op_e'(mode_i);
         keyless_q <= (key_len_i == '0);
         tidx_q    <= '0;
         tlen_q    <= tlen_c;
         kidx_q    <= '0;
         klen_q    <= klen_c;
      end else if (state_q == ST_RUN) begin
         if (step) begin
            tidx_q <= tidx_q + 1'b1;
            kidx_q <= (kidx_q + 1'b1 == klen_q) ? '0 : kidx_q + 1'b1;
         end else begin
            state_q <= ST_DONE;
         end
      end
   end

   assign run_o     = (state_q == ST_RUN);
   assign done_o    = (state_q == ST_DONE);
   assign op_o      = op_q;
   assign keyless_o = keyless_q;
   assign wr_en_o   = step;
   assign tidx_o    = tidx_q;
   assign tlen_o    = tlen_q;
   assign kidx_o    = kidx_q;
   assign klen_o    = klen_q;
endmodule

// File: rtl/vig_result_store.sv
module vig_result_store
   import vig_pkg::*;
#(
   parameter int MAX_TEXT = 16,
   parameter int TLEN_W   = $clog2(MAX_TEXT + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [TLEN_W-1:0]          wr_idx_i,
   input  letter_t                    wr_char_i,
   output logic [MAX_TEXT*CHAR_W-1:0] result_o
);
   generate
      for (genvar g = 0; g < MAX_TEXT; g++) begin : g_slot
         letter_t slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == TLEN_W'(g))) begin
               slot_q <= wr_char_i;
            end
         end
         assign result_o[g*CHAR_W +: CHAR_W] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/vig_seq_engine.sv
module vig_seq_engine
   import vig_pkg::*;
#(
   parameter int MAX_TEXT     = 16,
   parameter int MAX_KEY      = 8,
   parameter bit SHARED_ADDER = 1'b1,
   parameter int TLEN_W       = $clog2(MAX_TEXT + 1),
   parameter int KLEN_W       = $clog2(MAX_KEY + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       mode_i,
   input  logic [MAX_TEXT*CHAR_W-1:0] text_i,
   input  logic [TLEN_W-1:0]          text_len_i,
   input  logic [MAX_KEY*CHAR_W-1:0]  key_i,
   input  logic [KLEN_W-1:0]          key_len_i,
   output logic [MAX_TEXT*CHAR_W-1:0] result_o,
   output logic                       done_o
);
   generate
      if (MAX_TEXT < 1) begin : g_bad_text
         $error("MAX_TEXT must be at least 1");
      end
      if (MAX_KEY < 1) begin : g_bad_key
         $error("MAX_KEY must be at least 1");
      end
      if (TLEN_W < $clog2(MAX_TEXT + 1)) begin : g_bad_tlen
         $error("TLEN_W too narrow for MAX_TEXT");
      end
      if (KLEN_W < $clog2(MAX_KEY + 1)) begin : g_bad_klen
         $error("KLEN_W too narrow for MAX_KEY");
      end
   endgenerate

   logic              run_w, wr_en_w, keyless_w;
   op_e               mode_w;
   logic [TLEN_W-1:0] tidx_w, tlen_w;
   logic [KLEN_W-1:0] kidx_w, klen_w;
   letter_t           txt_ch_w, key_ch_w, res_ch_w;

   vig_index_ctrl #(
      .MAX_TEXT(MAX_TEXT), .MAX_KEY(MAX_KEY),
      .TLEN_W(TLEN_W), .KLEN_W(KLEN_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .text_len_i(text_len_i), .key_len_i(key_len_i),
      .run_o(run_w), .done_o(done_o), .op_o(mode_w),
      .keyless_o(keyless_w), .wr_en_o(wr_en_w),
      .tidx_o(tidx_w), .tlen_o(tlen_w), .kidx_o(kidx_w), .klen_o(klen_w)
   );

   always_comb begin
      txt_ch_w = '0;
      for (int i = 0; i < MAX_TEXT; i++) begin
         if (TLEN_W'(i) == tidx_w) txt_ch_w = text_i[i*CHAR_W +: CHAR_W];
      end
   end

   always_comb begin
      key_ch_w = '0;
      if (!keyless_w) begin
         for (int j = 0; j < MAX_KEY; j++) begin
            if (KLEN_W'(j) == kidx_w) key_ch_w = key_i[j*CHAR_W +: CHAR_W];
         end
      end
   end

   vig_mod26_unit #(.SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op_i(mode_w), .txt_i(txt_ch_w), .key_i(key_ch_w), .res_o(res_ch_w)
   );

   vig_result_store #(.MAX_TEXT(MAX_TEXT), .TLEN_W(TLEN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_w), .wr_idx_i(tidx_w),
      .wr_char_i(res_ch_w), .result_o(result_o)
   );
endmodule

// File: rtl/vig_seq_chk.sv
module vig_seq_chk #(
   parameter int TW = 5,
   parameter int KW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          run,
   input logic          done,
   input logic          mode_q,
   input logic [TW-1:0] tidx,
   input logic [TW-1:0] tlen,
   input logic [KW-1:0] kidx,
   input logic [KW-1:0] klen,
   input logic          wr_en,
   input logic [4:0]    wr_char
);
   // R1
   letter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_char < 5'd26));

   // R3
   key_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (kidx < klen));

   // R5
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(mode_q));

   // R6
   busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (tidx != tlen)) |=> (run && (tidx == $past(tidx) + 1'b1)));

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_i) |=> done);

   // R7
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(run) && ($past(tidx) == $past(tlen))));

   // R7
   state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({run, done}));
endmodule

bind vig_seq_engine vig_seq_chk #(.TW(TLEN_W), .KW(KLEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .run(run_w), .done(done_o),
   .mode_q(mode_w), .tidx(tidx_w), .tlen(tlen_w), .kidx(kidx_w),
   .klen(klen_w), .wr_en(wr_en_w), .wr_char(res_ch_w)
);

// File: tb/tb_vig_seq_engine.sv
`timescale 1ns/1ps
module tb_vig_seq_engine;
   localparam int MAX_TEXT = 16;
   localparam int MAX_KEY  = 8;
   localparam int TLEN_W   = $clog2(MAX_TEXT + 1);
   localparam int KLEN_W   = $clog2(MAX_KEY + 1);
   localparam int TXT_W    = MAX_TEXT * 5;
   localparam int KEY_W    = MAX_KEY * 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              mode_i = 1'b0;
   logic [TXT_W-1:0]  text_i = '0;
   logic [TLEN_W-1:0] text_len_i = '0;
   logic [KEY_W-1:0]  key_i = '0;
   logic [KLEN_W-1:0] key_len_i = '0;
   logic [TXT_W-1:0]  result_o;
   logic              done_o;

   int checks = 0;
   int errors = 0;
   logic [TXT_W-1:0] shadow = '0;

   always #2.5 clk = ~clk;

   vig_seq_engine #(.MAX_TEXT(MAX_TEXT), .MAX_KEY(MAX_KEY)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .text_i(text_i), .text_len_i(text_len_i), .key_i(key_i),
      .key_len_i(key_len_i), .result_o(result_o), .done_o(done_o)
   );

   function automatic logic [TXT_W-1:0] pack_txt(string s);
      logic [TXT_W-1:0] r = '0;
      for (int i = 0; i < s.len() && i < MAX_TEXT; i++) r[i*5 +: 5] = 5'(s[i] - 8'd65);
      return r;
   endfunction

   function automatic logic [KEY_W-1:0] pack_key(string s);
      logic [KEY_W-1:0] r = '0;
      for (int i = 0; i < s.len() && i < MAX_KEY; i++) r[i*5 +: 5] = 5'(s[i] - 8'd65);
      return r;
   endfunction

   function automatic logic [TXT_W-1:0] model(logic [TXT_W-1:0] prev, logic [TXT_W-1:0] txt,
                                              int tl, logic [KEY_W-1:0] ky, int kl, bit dec);
      logic [TXT_W-1:0] r = prev;
      int n = (tl > MAX_TEXT) ? MAX_TEXT : tl;
      int m = (kl > MAX_KEY) ? MAX_KEY : kl;
      for (int i = 0; i < n; i++) begin
         int p = int'(txt[i*5 +: 5]);
         int k = (m == 0) ? 0 : int'(ky[(i % m)*5 +: 5]);
         int v = dec ? (p + 26 - k) % 26 : (p + k) % 26;
         r[i*5 +: 5] = 5'(v);
      end
      return r;
   endfunction

   task automatic chk(bit ok, string req, logic [TXT_W-1:0] act, logic [TXT_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic launch(logic [TXT_W-1:0] txt, int tl, logic [KEY_W-1:0] ky, int kl, bit dec);
      @(negedge clk);
      text_i = txt; text_len_i = TLEN_W'(tl);
      key_i = ky; key_len_i = KLEN_W'(kl);
      mode_i = dec; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      shadow = model(shadow, txt, tl, ky, kl, dec);
   endtask

   // waits counting from the negedge right after the accepting edge
   task automatic wait_done(int n, int already, string req);
      repeat (n - already) @(negedge clk);
      chk(done_o == 1'b0, req, TXT_W'(done_o), '0);
      @(negedge clk);
      chk(done_o == 1'b1, req, TXT_W'(done_o), TXT_W'(1));
   endtask

   task automatic chk_result(string req);
      chk(result_o === shadow, req, result_o, shadow);
   endtask

   task automatic t_reset();
      chk(done_o == 1'b0, "R8 done", TXT_W'(done_o), '0);
      chk(result_o == '0, "R8 result", result_o, '0);
   endtask

   task automatic t_known_vector();
      logic [TXT_W-1:0] cexp = pack_txt("CVAGXHEOJQPZS");
      logic [TXT_W-1:0] pexp = pack_txt("SECRETMESSAGE");
      logic [64:0] msk = (65'd1 << 65) - 1;
      launch(pexp, 13, pack_key("KRYPTOS"), 7, 1'b0);
      wait_done(13, 0, "R7 latency enc");
      chk(result_o[64:0] == cexp[64:0], "R12 R1 R3 encrypt", TXT_W'(result_o[64:0] & msk), TXT_W'(cexp[64:0]));
      launch(result_o, 13, pack_key("KRYPTOS"), 7, 1'b1);
      wait_done(13, 0, "R7 latency dec");
      chk(result_o[64:0] == pexp[64:0], "R12 R2 decrypt", TXT_W'(result_o[64:0]), TXT_W'(pexp[64:0]));
      chk_result("R2 model");
   endtask

   task automatic t_wrap();
      launch(pack_txt("ZYXWVUTSRQPONMLK"), 16, pack_key("ZEBRA"), 5, 1'b0);
      wait_done(16, 0, "R7 latency wrap");
      chk_result("R3 wrap enc len5");
      launch(pack_txt("ABCDEFGHI"), 9, pack_key("ZZZZ"), 4, 1'b1);
      wait_done(9, 0, "R7 latency wrap dec");
      chk_result("R2 R3 R11 wrap dec underflow");
   endtask

   task automatic t_keyless();
      logic [TXT_W-1:0] t = pack_txt("HELLOWORLD");
      launch(t, 10, pack_key("XYZ"), 0, 1'b1);
      wait_done(10, 0, "R7 latency keyless");
      chk(result_o[49:0] == t[49:0], "R4 passthrough", result_o, t);
      chk_result("R4 model");
   endtask

   task automatic t_mode_mid();
      launch(pack_txt("MIDRUNMODECHANGE"), 16, pack_key("QUIET"), 5, 1'b0);
      @(negedge clk);
      mode_i = 1'b1; text_len_i = TLEN_W'(3); key_len_i = KLEN_W'(2);
      wait_done(16, 1, "R5 latency");
      chk_result("R5 mode held");
   endtask

   task automatic t_start_busy();
      launch(pack_txt("BUSYSTARTIGNORED"), 16, pack_key("ABCDEFGH"), 8, 1'b1);
      repeat (2) @(negedge clk);
      start_i = 1'b1; mode_i = 1'b0;
      text_len_i = TLEN_W'(4); key_len_i = KLEN_W'(1);
      @(negedge clk);
      start_i = 1'b0;
      wait_done(16, 3, "R6 latency");
      chk_result("R6 result");
   endtask

   task automatic t_done_hold();
      repeat (6) @(negedge clk);
      chk(done_o == 1'b1, "R7 hold", TXT_W'(done_o), TXT_W'(1));
   endtask

   task automatic t_len0();
      launch(pack_txt("QQQQQQQQ"), 0, pack_key("K"), 1, 1'b0);
      chk(done_o == 1'b0, "R9 done low", TXT_W'(done_o), '0);
      @(negedge clk);
      chk(done_o == 1'b1, "R9 done", TXT_W'(done_o), TXT_W'(1));
      chk_result("R9 R11 unchanged");
   endtask

   task automatic t_tail();
      launch(pack_txt("TAILS"), 5, pack_key("OK"), 2, 1'b0);
      wait_done(5, 0, "R7 latency tail");
      chk_result("R11 tail kept");
   endtask

   task automatic t_clamp();
      launch(pack_txt("CLAMPEDLENGTHSXY"), 20, pack_key("LONGKEYS"), 12, 1'b0);
      wait_done(16, 0, "R10 latency");
      chk_result("R10 clamp");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_known_vector();
      t_done_hold();
      t_wrap();
      t_keyless();
      t_mode_mid();
      t_start_busy();
      t_len0();
      t_tail();
      t_clamp();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule